// File: doc/BRIEF.md
# Temperature-Driven Fan Duty Controller

This block sets an 8-bit PWM duty word for one fan. One of eight 8-bit temperature lanes is picked by a 3-bit select. The chosen reading is compared with a programmable upper boundary and a lower threshold, which is that boundary minus a hysteresis value. The comparison places the reading in one of three zones: hot, cold, or the band between them.

In the hot zone the duty either climbs one step at a time or is loaded at once with a high-zone duty. In the cold zone it either falls one step at a time or is loaded at once with a low-zone duty. Each direction has its own jump enable, and those enables count only in duty mode. In the band the duty holds its value. When interpolation is on, the duty instead walks toward a point on the line between the low-zone and high-zone duties. That point sits in proportion to where the reading lies inside the band. Every gradual step is paced by a free-running tick counter whose period comes from a 2-bit rate field.

Top module: `fan_duty_ctrl`

## Requirements
- R1: While `rst_n` is low, `duty` is 0x80 (parameter RST_DUTY) and the tick counter is cleared. This holds even if a reset is applied in the middle of a ramp.
- R2: Select code n (0..7) routes bits [8n+7:8n] of `temp_bus` to the comparison.
- R3: When the selected reading is greater than `upper_bound`, `duty_mode` is 1 and `jump_hi_en` is 1, `duty` equals `hi_duty` one cycle later.
- R4: When the reading is greater than `upper_bound` and no jump applies, `duty` rises by 1 on each tick. It stops at 0xFF.
- R5: When the reading is less than the lower threshold, `duty_mode` is 1 and `jump_lo_en` is 1, `duty` equals `lo_duty` one cycle later.
- R6: When the reading is less than the lower threshold and no jump applies, `duty` falls by 1 on each tick. It stops at 0x00.
- R7: With `duty_mode` at 0, both jump enables are ignored and the hot and cold zones ramp as in R4 and R6.
- R8: When the reading is neither above `upper_bound` nor below the lower threshold (the two bounds included in the band) and `interp_en` is 0, `duty` holds its value, whatever the jump enables are.
- R9: In the band with `interp_en` at 1, the target is lo_duty + (hi_duty - lo_duty) * (reading - threshold) / (upper_bound - threshold), using the signed difference and truncating the quotient toward lo_duty. The target is lo_duty when the band width is 0. On each tick `duty` moves 1 toward the target, and it stays there once reached.
- R10: A tick comes every 2^(4+rate_sel) cycles. After reset is released, the first tick falls on the 2^(4+rate_sel)-th rising edge, and no step is taken outside a tick.
- R11: The lower threshold is `upper_bound - hyst`, but 0 when `hyst` is greater than `upper_bound`. In that case no reading is in the cold zone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_bus | input | 64 | Eight 8-bit temperature lanes, lane n at bits [8n+7:8n] |
| src_sel | input | 3 | Temperature lane select |
| duty_mode | input | 1 | 1 = duty mode (jump enables active) |
| upper_bound | input | 8 | Upper temperature boundary |
| hyst | input | 8 | Hysteresis below the boundary |
| rate_sel | input | 2 | Ramp pace, tick every 2^(4+rate_sel) cycles |
| jump_hi_en | input | 1 | Load hi_duty at once in the hot zone |
| jump_lo_en | input | 1 | Load lo_duty at once in the cold zone |
| hi_duty | input | 8 | High-zone duty |
| lo_duty | input | 8 | Low-zone duty |
| interp_en | input | 1 | Interpolate toward a band target |
| duty | output | 8 | Current PWM duty |

## Verification
The hardest states to reach from the ports are two. One is interpolation settling exactly on its target, with a quotient that truncates and a span where hi_duty is below lo_duty. The other is the threshold clamp when the hysteresis exceeds the boundary. The bench resets before every vector, so the phase of the tick counter is known. It then runs each band case for well over the cycles needed to reach the target, so any overshoot or oscillation shows in the final value. Boundary equality and clamp cases use lane values chosen to sit exactly on, or just across, each threshold.

// File: rtl/fan_duty_ctrl.sv
module fan_duty_ctrl #(
  parameter int N_SRC = 8,
  parameter int TW = 8,
  parameter int DW = 8,
  parameter int RW = 2,
  parameter int BASE_SHIFT = 4,
  parameter logic [DW-1:0] RST_DUTY = 8'h80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC*TW-1:0]  temp_bus,
  input  logic [$clog2(N_SRC)-1:0] src_sel,
  input  logic                 duty_mode,
  input  logic [TW-1:0]        upper_bound,
  input  logic [TW-1:0]        hyst,
  input  logic [RW-1:0]        rate_sel,
  input  logic                 jump_hi_en,
  input  logic                 jump_lo_en,
  input  logic [DW-1:0]        hi_duty,
  input  logic [DW-1:0]        lo_duty,
  input  logic                 interp_en,
  output logic [DW-1:0]        duty
);
  localparam int CW = BASE_SHIFT + (1 << RW) - 1;
  localparam int PW = DW + TW;

  logic [TW-1:0] t_sel, lo_thr, width, offs;
  logic          hot, cold;
  logic [CW-1:0] cnt, mask;
  logic          tick;
  logic          up_dir;
  logic [DW-1:0] span, itgt, nxt;
  logic [PW-1:0] prod, frac;

  assign t_sel  = temp_bus[src_sel*TW +: TW];
  assign lo_thr = (hyst > upper_bound) ? '0 : upper_bound - hyst;
  assign hot    = t_sel > upper_bound;
  assign cold   = t_sel < lo_thr;
  assign width  = upper_bound - lo_thr;
  assign offs   = t_sel - lo_thr;

  assign mask = CW'((1 << (BASE_SHIFT + int'(rate_sel))) - 1);
  assign tick = (cnt & mask) == mask;

  assign up_dir = hi_duty >= lo_duty;
  assign span   = up_dir ? hi_duty - lo_duty : lo_duty - hi_duty;
  assign prod   = {{TW{1'b0}}, span} * {{DW{1'b0}}, offs};
  assign frac   = (width == '0) ? '0 : prod / {{DW{1'b0}}, width};
  assign itgt   = up_dir ? lo_duty + frac[DW-1:0] : lo_duty - frac[DW-1:0];

  always_comb begin
    nxt = duty;
    if (hot) begin
      if (duty_mode && jump_hi_en)   nxt = hi_duty;
      else if (tick && duty != '1)   nxt = duty + 1'b1;
    end else if (cold) begin
      if (duty_mode && jump_lo_en)   nxt = lo_duty;
      else if (tick && duty != '0)   nxt = duty - 1'b1;
    end else if (interp_en && tick) begin
      if (duty < itgt)               nxt = duty + 1'b1;
      else if (duty > itgt)          nxt = duty - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      duty <= RST_DUTY;
    end else begin
      cnt  <= cnt + 1'b1;
      duty <= nxt;
    end
  end
endmodule

// File: rtl/fan_duty_ctrl_chk.sv
module fan_duty_ctrl_chk #(
  parameter int N_SRC = 8,
  parameter int TW = 8,
  parameter int DW = 8,
  parameter int RW = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_SRC*TW-1:0]  temp_bus,
  input logic [$clog2(N_SRC)-1:0] src_sel,
  input logic                 duty_mode,
  input logic [TW-1:0]        upper_bound,
  input logic [TW-1:0]        hyst,
  input logic                 jump_hi_en,
  input logic                 jump_lo_en,
  input logic [DW-1:0]        hi_duty,
  input logic [DW-1:0]        lo_duty,
  input logic                 interp_en,
  input logic [DW-1:0]        duty
);
  logic [TW-1:0] rd, floor_t;
  logic          is_hot, is_cold, do_jump;

  assign rd      = temp_bus[src_sel*TW +: TW];
  assign floor_t = (upper_bound >= hyst) ? upper_bound - hyst : '0;
  assign is_hot  = rd > upper_bound;
  assign is_cold = rd < floor_t;
  assign do_jump = duty_mode && ((jump_hi_en && is_hot) || (jump_lo_en && is_cold));

  a_r3_jump_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (is_hot && duty_mode && jump_hi_en) |=> duty == $past(hi_duty));

  a_r5_jump_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cold && duty_mode && jump_lo_en) |=> duty == $past(lo_duty));

  a_r4_hot_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (is_hot && !(duty_mode && jump_hi_en)) |=> duty >= $past(duty));

  a_r6_cold_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cold && !(duty_mode && jump_lo_en)) |=> duty <= $past(duty));

  a_r8_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_hot && !is_cold && !interp_en) |=> $stable(duty));

  a_r10_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !do_jump |=> (duty == $past(duty) || duty == $past(duty) + DW'(1) ||
                  duty == $past(duty) - DW'(1)));
endmodule

bind fan_duty_ctrl fan_duty_ctrl_chk #(.N_SRC(N_SRC), .TW(TW), .DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .temp_bus(temp_bus), .src_sel(src_sel),
  .duty_mode(duty_mode), .upper_bound(upper_bound), .hyst(hyst),
  .jump_hi_en(jump_hi_en), .jump_lo_en(jump_lo_en), .hi_duty(hi_duty),
  .lo_duty(lo_duty), .interp_en(interp_en), .duty(duty)
);

// File: tb/fan_duty_ctrl_bench.sv
module fan_duty_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] temp_bus;
  logic [2:0]  src_sel = '0;
  logic        duty_mode = 1'b0;
  logic [7:0]  upper_bound = '0, hyst = '0, hi_duty = '0, lo_duty = '0;
  logic [1:0]  rate_sel = '0;
  logic        jump_hi_en = 1'b0, jump_lo_en = 1'b0, interp_en = 1'b0;
  logic [7:0]  duty;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  // lanes 0..7: 10 28 40 58 70 88 A0 B8
  assign temp_bus = {8'hB8, 8'hA0, 8'h88, 8'h70, 8'h58, 8'h40, 8'h28, 8'h10};

  fan_duty_ctrl u_fan_duty_ctrl (
    .clk(clk), .rst_n(rst_n), .temp_bus(temp_bus), .src_sel(src_sel),
    .duty_mode(duty_mode), .upper_bound(upper_bound), .hyst(hyst),
    .rate_sel(rate_sel), .jump_hi_en(jump_hi_en), .jump_lo_en(jump_lo_en),
    .hi_duty(hi_duty), .lo_duty(lo_duty), .interp_en(interp_en), .duty(duty)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [7:0]  ub;
    logic [7:0]  hy;
    logic        md;
    logic        jh;
    logic        jl;
    logic        ip;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [1:0]  rt;
    logic [15:0] ncyc;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{3'd5, 8'h80, 8'h10, 1'b1, 1'b1, 1'b0, 1'b0, 8'hE0, 8'h30, 2'd0, 16'd1,    8'hE0, 4'd3},  // R3
    '{3'd5, 8'h80, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE0, 8'h30, 2'd0, 16'd80,   8'h85, 4'd4},  // R4
    '{3'd5, 8'h80, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE0, 8'h30, 2'd2, 16'd200,  8'h83, 4'd10}, // R10
    '{3'd5, 8'h80, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE0, 8'h30, 2'd0, 16'd15,   8'h80, 4'd10}, // R10
    '{3'd5, 8'h80, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE0, 8'h30, 2'd0, 16'd16,   8'h81, 4'd10}, // R10
    '{3'd5, 8'h80, 8'h10, 1'b0, 1'b1, 1'b0, 1'b0, 8'hE0, 8'h30, 2'd0, 16'd48,   8'h83, 4'd7},  // R7
    '{3'd5, 8'h80, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE0, 8'h30, 2'd0, 16'd3200, 8'hFF, 4'd4},  // R4
    '{3'd1, 8'h80, 8'h10, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE0, 8'h30, 2'd0, 16'd1,    8'h30, 4'd5},  // R5
    '{3'd1, 8'h80, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE0, 8'h30, 2'd1, 16'd160,  8'h7B, 4'd6},  // R6
    '{3'd1, 8'h80, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0, 8'hE0, 8'h30, 2'd3, 16'd256,  8'h7E, 4'd7},  // R7
    '{3'd1, 8'h80, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE0, 8'h30, 2'd0, 16'd3200, 8'h00, 4'd6},  // R6
    '{3'd4, 8'h80, 8'h10, 1'b1, 1'b1, 1'b1, 1'b0, 8'hE0, 8'h30, 2'd0, 16'd100,  8'h80, 4'd8},  // R8
    '{3'd4, 8'h70, 8'h10, 1'b1, 1'b1, 1'b1, 1'b0, 8'hE0, 8'h30, 2'd0, 16'd5,    8'h80, 4'd8},  // R8
    '{3'd4, 8'h80, 8'h20, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA0, 8'h20, 2'd0, 16'd1000, 8'h60, 4'd9},  // R9
    '{3'd4, 8'h78, 8'h20, 1'b1, 1'b0, 1'b0, 1'b1, 8'h10, 8'hF0, 2'd0, 16'd1200, 8'h48, 4'd9},  // R9
    '{3'd4, 8'h80, 8'h20, 1'b1, 1'b0, 1'b0, 1'b1, 8'hD0, 8'h90, 2'd0, 16'd900,  8'hB0, 4'd9},  // R9
    '{3'd0, 8'h20, 8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE0, 8'h30, 2'd0, 16'd10,   8'h80, 4'd11}, // R11
    '{3'd7, 8'hB0, 8'h04, 1'b1, 1'b1, 1'b1, 1'b0, 8'hE0, 8'h30, 2'd0, 16'd1,    8'hE0, 4'd2},  // R2
    '{3'd6, 8'hB0, 8'h04, 1'b1, 1'b1, 1'b1, 1'b0, 8'hE0, 8'h30, 2'd0, 16'd1,    8'h30, 4'd2}   // R2
  };

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d: duty=%02h expected %02h", req, got, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    src_sel = v.sel;   upper_bound = v.ub; hyst = v.hy;
    duty_mode = v.md;  jump_hi_en = v.jh;  jump_lo_en = v.jl;
    interp_en = v.ip;  hi_duty = v.hi;     lo_duty = v.lo;
    rate_sel = v.rt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset holds the default even with a hot jump pending
    apply(VECS[0]);
    repeat (3) @(posedge clk);
    #1 check(1, duty, 8'h80);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) rst_n = 1'b0;
      apply(VECS[i]);
      @(negedge clk) rst_n = 1'b1;
      repeat (int'(VECS[i].ncyc)) @(posedge clk);
      #1 check(int'(VECS[i].req), duty, VECS[i].exp);
    end

    // R1: reset in the middle of a hot ramp returns to default
    @(negedge clk) rst_n = 1'b0;
    apply(VECS[1]);
    @(negedge clk) rst_n = 1'b1;
    repeat (100) @(posedge clk);
    #1 check(4, duty, 8'h86);
    @(negedge clk) rst_n = 1'b0;
    #1 check(1, duty, 8'h80);
    // R10: counter restarts, so first step again on the 16th edge
    @(negedge clk) rst_n = 1'b1;
    repeat (16) @(posedge clk);
    #1 check(10, duty, 8'h81);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule